// File: doc/BRIEF.md
# Nibble-Serial Debug Memory Monitor

This block lets an external debug host read or write single locations on an internal memory bus through a 4-bit data port. The host frames each request with a sync strobe. While the strobe is high, the block takes one nibble per clock: a spare nibble, a command nibble, the address and, for writes only, the data. It then issues one access on a request/response bus and reports progress on its own 4-bit output. It drives a busy status while the access runs, then a final status that can carry a command-error flag or a bus-error flag.

After a successful read, the host drops the strobe. The block then returns the read data one nibble per clock, least significant nibble first, and the number of nibbles depends on the size field of the command. Monitor operation is chosen at reset: the mode input is sampled while reset is held and is frozen when reset is released.

Top module: `nib_dbg_mon`

## Requirements
- R1: The mode input is captured while rst_n is low and is ignored after release. If it was captured low, the block raises no bus request, keeps dout_en_o low and ignores sync_i and din_i.
- R2: A frame is a spare nibble (value ignored), then a command nibble, then ADDR_NIBS address nibbles with the least significant nibble first. One clock after the last nibble the frame needs, bus_req_o rises carrying that address.
- R3: Command nibble bit 3 must be 1. Bit 2 selects write (1) or read (0), and it drives bus_we_o. Bits 1:0 select the size, 00 byte, 01 word or 10 longword, and they drive bus_size_o.
- R4: A write frame carries 2, 4 or 8 data nibbles (byte, word, longword), least significant first. bus_wdata_o holds them with all higher bits zero.
- R5: bus_req_o stays high, with address, direction and size held unchanged, until a cycle in which bus_gnt_i is high. It drops in the following cycle.
- R6: From the request until the response arrives, dout_en_o is high and dout_o shows the busy status 0000.
- R7: A response without an error gives status 0001 on dout_o in the following cycle.
- R8: A command nibble with bit 3 clear, or with size bits 11, ends the frame. Status 0011 follows in the next cycle and no bus request is made.
- R9: A response with bus_err_i high gives status 0101, and no read data is returned afterwards.
- R10: After a successful read, sync_i low in a cycle that shows the status starts read data on dout_o on the next cycle. The data comes as 2, 4 or 8 nibbles, least significant first, with dout_en_o high, and dout_en_o falls after the last nibble.
- R11: sync_i falling before a frame is complete discards the frame. No bus request is made and dout_en_o stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, synchronous |
| mode_i | input | 1 | Monitor enable, sampled during reset |
| sync_i | input | 1 | Frame strobe from host |
| din_i | input | 4 | Nibble from host |
| dout_o | output | 4 | Status or read data nibble |
| dout_en_o | output | 1 | dout_o is valid and driven |
| bus_req_o | output | 1 | Bus request valid |
| bus_gnt_i | input | 1 | Bus request accepted |
| bus_we_o | output | 1 | Request is a write |
| bus_size_o | output | 2 | Access size code |
| bus_addr_o | output | 4*ADDR_NIBS | Access address |
| bus_wdata_o | output | 32 | Write data |
| bus_rsp_i | input | 1 | Response valid |
| bus_rdata_i | input | 32 | Read data of response |
| bus_err_i | input | 1 | Response carries a bus error |

## Verification
The bench builds the block with the default ADDR_NIBS of 8, which gives a full 32-bit address. At that setting every byte lane of the address and all three access sizes reach the bus, and the longest write frame of 18 nibbles exercises the widest frame counter. Grant and response delays vary from zero to several cycles, so that holding of the request and the busy status are both seen. The same delays show that read data is returned only after the strobe drops.

// File: rtl/nm_pkg.sv
package nm_pkg;
  localparam int DATA_NIBS = 8;
  localparam logic [3:0] STAT_BUSY   = 4'b0000;
  localparam logic [3:0] STAT_OK     = 4'b0001;
  localparam logic [3:0] STAT_CMDERR = 4'b0011;
  localparam logic [3:0] STAT_BUSERR = 4'b0101;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RECV, ST_REQ, ST_RSP, ST_DONE
  } nm_state_e;

  function automatic logic cmd_ok(input logic [3:0] c);
    return c[3] && (c[1:0] != 2'b11);
  endfunction

  function automatic logic [3:0] size_nibs(input logic [1:0] sz);
    case (sz)
      2'b00:   return 4'd2;
      2'b01:   return 4'd4;
      default: return 4'd8;
    endcase
  endfunction
endpackage

// File: rtl/nm_cmd_dec.sv
module nm_cmd_dec
  import nm_pkg::*;
(
  input  logic [3:0] cmd_i,
  output logic       ok_o,
  output logic       we_o,
  output logic [1:0] size_o,
  output logic [3:0] nibs_o
);
  always_comb begin
    ok_o   = cmd_ok(cmd_i);
    we_o   = cmd_i[2];
    size_o = cmd_i[1:0];
    nibs_o = size_nibs(cmd_i[1:0]);
  end
endmodule

// File: rtl/nm_rd_ser.sv
module nm_rd_ser (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load_i,
  input  logic [31:0] data_i,
  input  logic [3:0]  nibs_i,
  output logic [3:0]  nib_o,
  output logic        busy_o
);
  logic [31:0] sh_q;
  logic [3:0]  left_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sh_q   <= '0;
      left_q <= '0;
    end else if (load_i) begin
      sh_q   <= data_i;
      left_q <= nibs_i;
    end else if (left_q != 4'd0) begin
      sh_q   <= sh_q >> 4;
      left_q <= left_q - 4'd1;
    end
  end

  assign nib_o  = sh_q[3:0];
  assign busy_o = (left_q != 4'd0);
endmodule

// File: rtl/nib_dbg_mon.sv
module nib_dbg_mon
  import nm_pkg::*;
#(
  parameter int ADDR_NIBS = 8
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   mode_i,
  input  logic                   sync_i,
  input  logic [3:0]             din_i,
  output logic [3:0]             dout_o,
  output logic                   dout_en_o,
  output logic                   bus_req_o,
  input  logic                   bus_gnt_i,
  output logic                   bus_we_o,
  output logic [1:0]             bus_size_o,
  output logic [4*ADDR_NIBS-1:0] bus_addr_o,
  output logic [31:0]            bus_wdata_o,
  input  logic                   bus_rsp_i,
  input  logic [31:0]            bus_rdata_i,
  input  logic                   bus_err_i
);
  localparam int AW         = 4 * ADDR_NIBS;
  localparam int FIRST_ADDR = 2;
  localparam int FIRST_DATA = FIRST_ADDR + ADDR_NIBS;
  localparam int CNT_W      = $clog2(FIRST_DATA + DATA_NIBS + 1);

  nm_state_e        state_q;
  logic [CNT_W-1:0] cnt_q;
  logic [3:0]       cmd_q;
  logic [3:0]       stat_q;
  logic [31:0]      rdata_q;
  logic [AW-1:0]    addr_q;
  logic [31:0]      wdata_q;
  logic             mon_q;

  logic       at_cmd, dec_ok, dec_we;
  logic [1:0] dec_size;
  logic [3:0] dec_nibs, dec_in;
  logic       frame_start, cmd_err_evt, rsp_evt, ser_load, ser_busy;
  logic [3:0] ser_nib;
  logic [CNT_W-1:0] last_idx;

  // mode is frozen at reset release
  always_ff @(posedge clk) begin
    if (!rst_n) mon_q <= mode_i;
  end

  assign at_cmd = (state_q == ST_RECV) && (cnt_q == CNT_W'(1));
  assign dec_in = at_cmd ? din_i : cmd_q;

  nm_cmd_dec u_dec (
    .cmd_i (dec_in),
    .ok_o  (dec_ok),
    .we_o  (dec_we),
    .size_o(dec_size),
    .nibs_o(dec_nibs)
  );

  assign frame_start = (state_q == ST_IDLE) && mon_q && sync_i && !ser_busy;
  assign cmd_err_evt = at_cmd && sync_i && !dec_ok;
  assign rsp_evt     = (state_q == ST_RSP) && bus_rsp_i;
  assign ser_load    = (state_q == ST_DONE) && !sync_i && (stat_q == STAT_OK) && !dec_we;
  assign last_idx    = CNT_W'(FIRST_DATA - 1) + (dec_we ? CNT_W'(dec_nibs) : '0);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      cmd_q   <= '0;
      stat_q  <= STAT_BUSY;
      rdata_q <= '0;
    end else begin
      case (state_q)
        ST_IDLE: if (frame_start) begin
          state_q <= ST_RECV;
          cnt_q   <= CNT_W'(1);
        end
        ST_RECV: begin
          if (!sync_i) begin
            state_q <= ST_IDLE;
          end else if (at_cmd) begin
            if (!dec_ok) begin
              state_q <= ST_DONE;
              stat_q  <= STAT_CMDERR;
            end else begin
              cmd_q <= din_i;
              cnt_q <= cnt_q + CNT_W'(1);
            end
          end else if (cnt_q == last_idx) begin
            state_q <= ST_REQ;
          end else begin
            cnt_q <= cnt_q + CNT_W'(1);
          end
        end
        ST_REQ: if (bus_gnt_i) state_q <= ST_RSP;
        ST_RSP: if (bus_rsp_i) begin
          state_q <= ST_DONE;
          stat_q  <= bus_err_i ? STAT_BUSERR : STAT_OK;
          rdata_q <= bus_rdata_i;
        end
        ST_DONE: if (!sync_i) state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // one capture register per address and data nibble
  for (genvar g = 0; g < ADDR_NIBS; g++) begin : g_addr
    always_ff @(posedge clk) begin
      if (!rst_n || frame_start) addr_q[4*g +: 4] <= '0;
      else if (state_q == ST_RECV && sync_i && cnt_q == CNT_W'(FIRST_ADDR + g))
        addr_q[4*g +: 4] <= din_i;
    end
  end

  for (genvar g = 0; g < DATA_NIBS; g++) begin : g_wdata
    always_ff @(posedge clk) begin
      if (!rst_n || frame_start) wdata_q[4*g +: 4] <= '0;
      else if (state_q == ST_RECV && sync_i && cnt_q == CNT_W'(FIRST_DATA + g))
        wdata_q[4*g +: 4] <= din_i;
    end
  end

  nm_rd_ser u_ser (
    .clk   (clk),
    .rst_n (rst_n),
    .load_i(ser_load),
    .data_i(rdata_q),
    .nibs_i(dec_nibs),
    .nib_o (ser_nib),
    .busy_o(ser_busy)
  );

  always_comb begin
    dout_o    = 4'b0000;
    dout_en_o = 1'b0;
    if (ser_busy) begin
      dout_o    = ser_nib;
      dout_en_o = 1'b1;
    end else if (state_q == ST_REQ || state_q == ST_RSP) begin
      dout_o    = STAT_BUSY;
      dout_en_o = 1'b1;
    end else if (state_q == ST_DONE) begin
      dout_o    = stat_q;
      dout_en_o = 1'b1;
    end
  end

  assign bus_req_o   = (state_q == ST_REQ);
  assign bus_we_o    = dec_we;
  assign bus_size_o  = dec_size;
  assign bus_addr_o  = addr_q;
  assign bus_wdata_o = wdata_q;
endmodule

// File: rtl/nm_chk.sv
module nm_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          mon_q,
  input logic          cmd_err_evt,
  input logic          rsp_evt,
  input logic          bus_err_i,
  input logic          bus_req_o,
  input logic          bus_gnt_i,
  input logic          bus_we_o,
  input logic [1:0]    bus_size_o,
  input logic [AW-1:0] bus_addr_o,
  input logic [3:0]    dout_o,
  input logic          dout_en_o
);
  AST_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !mon_q |-> (!bus_req_o && !dout_en_o)); // R1
  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && !bus_gnt_i) |=> (bus_req_o && $stable(bus_addr_o) && $stable(bus_we_o) && $stable(bus_size_o))); // R5
  AST_REQ_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req_o && bus_gnt_i) |=> !bus_req_o); // R5
  AST_BUSY_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    bus_req_o |-> (dout_en_o && dout_o == 4'b0000)); // R6
  AST_OK_STAT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_evt && !bus_err_i) |=> (dout_en_o && dout_o == 4'b0001)); // R7
  AST_CMD_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_err_evt |=> (dout_o == 4'b0011 && !bus_req_o)); // R8
  AST_BUS_ERR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_evt && bus_err_i) |=> (dout_en_o && dout_o == 4'b0101)); // R9
endmodule

bind nib_dbg_mon nm_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mon_q      (mon_q),
  .cmd_err_evt(cmd_err_evt),
  .rsp_evt    (rsp_evt),
  .bus_err_i  (bus_err_i),
  .bus_req_o  (bus_req_o),
  .bus_gnt_i  (bus_gnt_i),
  .bus_we_o   (bus_we_o),
  .bus_size_o (bus_size_o),
  .bus_addr_o (bus_addr_o),
  .dout_o     (dout_o),
  .dout_en_o  (dout_en_o)
);

// File: tb/sim_nib_dbg_mon.sv
module sim_nib_dbg_mon;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        mode_i = 1'b1;
  logic        sync_i = 1'b0;
  logic [3:0]  din_i = '0;
  logic [3:0]  dout_o;
  logic        dout_en_o, bus_req_o, bus_we_o;
  logic        bus_gnt_i = 1'b0, bus_rsp_i = 1'b0, bus_err_i = 1'b0;
  logic [1:0]  bus_size_o;
  logic [31:0] bus_addr_o, bus_wdata_o;
  logic [31:0] bus_rdata_i = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  nib_dbg_mon u0 (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .sync_i(sync_i), .din_i(din_i),
    .dout_o(dout_o), .dout_en_o(dout_en_o), .bus_req_o(bus_req_o),
    .bus_gnt_i(bus_gnt_i), .bus_we_o(bus_we_o), .bus_size_o(bus_size_o),
    .bus_addr_o(bus_addr_o), .bus_wdata_o(bus_wdata_o), .bus_rsp_i(bus_rsp_i),
    .bus_rdata_i(bus_rdata_i), .bus_err_i(bus_err_i)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic send_nib(input logic [3:0] v);
    sync_i = 1'b1;
    din_i  = v;
    tick();
  endtask

  task automatic do_reset(input logic mode);
    rst_n = 1'b0; mode_i = mode; sync_i = 1'b0;
    repeat (3) tick();
    rst_n = 1'b1;
    mode_i = ~mode;   // later changes must not matter
    tick();
  endtask

  // one complete frame, compared against the expected port behaviour every clock
  task automatic frame(input logic [3:0] cmd, input logic [31:0] addr, input logic [31:0] wd,
                       input int gd, input int rd, input bit err, input logic [31:0] rdat);
    bit ok = cmd[3] && (cmd[1:0] != 2'b11);
    bit we = cmd[2];
    int n = (cmd[1:0] == 2'b00) ? 2 : (cmd[1:0] == 2'b01) ? 4 : 8;
    logic [31:0] mask = (n == 8) ? 32'hffff_ffff : ((32'h1 << (4 * n)) - 32'h1);
    send_nib(4'h0);
    send_nib(cmd);
    if (!ok) begin
      chk("R8 status", {dout_en_o, dout_o}, {1'b1, 4'b0011});
      chk("R8 no request", bus_req_o, 0);
      sync_i = 1'b0; tick();
      chk("R8 released", dout_en_o, 0);
      return;
    end
    for (int i = 0; i < 8; i++) begin
      chk("R11 no early request", bus_req_o, 0);
      send_nib(addr[4*i +: 4]);
    end
    if (we) for (int i = 0; i < n; i++) send_nib(wd[4*i +: 4]);
    din_i = 4'h0;
    chk("R2 request", bus_req_o, 1);
    chk("R2 address", bus_addr_o, addr);
    chk("R3 direction", bus_we_o, we);
    chk("R3 size", bus_size_o, cmd[1:0]);
    if (we) chk("R4 write data", bus_wdata_o, wd & mask);
    chk("R6 busy", {dout_en_o, dout_o}, {1'b1, 4'b0000});
    for (int i = 0; i < gd; i++) begin
      tick();
      chk("R5 held", {bus_req_o, bus_addr_o}, {1'b1, addr});
      chk("R6 busy held", {dout_en_o, dout_o}, {1'b1, 4'b0000});
    end
    bus_gnt_i = 1'b1; tick(); bus_gnt_i = 1'b0;
    chk("R5 dropped", bus_req_o, 0);
    chk("R6 busy waiting", {dout_en_o, dout_o}, {1'b1, 4'b0000});
    for (int i = 0; i < rd; i++) begin
      tick();
      chk("R6 busy waiting", {dout_en_o, dout_o}, {1'b1, 4'b0000});
    end
    bus_rsp_i = 1'b1; bus_err_i = err; bus_rdata_i = rdat;
    tick();
    bus_rsp_i = 1'b0; bus_err_i = 1'b0; bus_rdata_i = 32'hdead_beef;
    if (err) chk("R9 bus error status", {dout_en_o, dout_o}, {1'b1, 4'b0101});
    else     chk("R7 ready status", {dout_en_o, dout_o}, {1'b1, 4'b0001});
    sync_i = 1'b0; tick();
    if (!we && !err) begin
      for (int i = 0; i < n; i++) begin
        chk("R10 read nibble", {dout_en_o, dout_o}, {1'b1, rdat[4*i +: 4]});
        tick();
      end
    end
    if (err && !we) chk("R9 no read data", dout_en_o, 0);
    else            chk("R10 output released", dout_en_o, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    // R1: monitor disabled when mode is low at reset release
    do_reset(1'b0);
    chk("R1 reset state", {bus_req_o, dout_en_o}, 0);
    send_nib(4'h0); send_nib(4'h8);
    for (int i = 0; i < 8; i++) send_nib(4'h3);
    for (int i = 0; i < 4; i++) begin
      chk("R1 ignored", {bus_req_o, dout_en_o}, 0);
      tick();
    end
    sync_i = 1'b0; tick();

    do_reset(1'b1);
    chk("R1 reset state enabled", {bus_req_o, dout_en_o, dout_o}, 0);

    frame(4'b1000, 32'h1234_5678, 32'h0, 0, 0, 1'b0, 32'h0000_00a5); // read byte
    frame(4'b1001, 32'hfedc_ba98, 32'h0, 2, 1, 1'b0, 32'h1111_c3e7); // read word
    frame(4'b1010, 32'h0000_0001, 32'h0, 1, 3, 1'b0, 32'h89ab_cdef); // read long
    frame(4'b1100, 32'h8000_0000, 32'hffff_ff5a, 0, 1, 1'b0, 32'h0); // write byte
    frame(4'b1101, 32'h55aa_55aa, 32'h1234_9876, 3, 0, 1'b0, 32'h0); // write word
    frame(4'b1110, 32'hcafe_f00d, 32'h7654_3210, 1, 2, 1'b0, 32'h0); // write long
    frame(4'b1010, 32'h0bad_0bad, 32'h0, 1, 1, 1'b1, 32'h1234_5678); // R9 read error
    frame(4'b1110, 32'h0bad_0bad, 32'habcd_ef01, 0, 0, 1'b1, 32'h0); // R9 write error
    frame(4'b0010, 32'h0, 32'h0, 0, 0, 1'b0, 32'h0);                 // R8 bit 3 clear
    frame(4'b1011, 32'h0, 32'h0, 0, 0, 1'b0, 32'h0);                 // R8 size 11

    // R11: strobe drops mid-address
    send_nib(4'h0); send_nib(4'h8);
    send_nib(4'h1); send_nib(4'h2); send_nib(4'h3);
    sync_i = 1'b0; tick();
    for (int i = 0; i < 3; i++) begin
      chk("R11 aborted", {bus_req_o, dout_en_o}, 0);
      tick();
    end
    frame(4'b1001, 32'h2468_ace0, 32'h0, 0, 0, 1'b0, 32'h0000_9a3c); // R11 recovery

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule